// File: doc/BRIEF.md
# BCD Alarm Match and Repeat Controller

This block keeps four alarm registers, for seconds, minutes, hours and day of month, all in BCD. It compares them with the BCD time of day that an external clock counter supplies. A byte-wide write port loads the registers, and a combinational read port returns them. On each seconds tick from the counter, the block tests the enabled fields against the current time. When they agree, it produces a single-cycle interrupt pulse.

Bit 7 of every alarm register is a "don't care" flag for its field. Taken together, the four flags form a repeat-rate code that chooses which fields take part in the comparison. The alarm can therefore fire once a month, once a day, once an hour, once a minute or on every second. A write whose BCD value falls outside the legal range for its field is dropped, and the register keeps its previous contents.

Top module: `alm_match_ctrl`

## Requirements
- R1: After reset, all four alarm registers read 0x00 and `irq` is low.
- R2: Register select 0 (seconds) and 1 (minutes) use bits 6:4 as the tens digit and bits 3:0 as the units digit. A write is accepted only when tens*10+units is at most 59. A rejected write leaves the register unchanged.
- R3: Register select 2 (hours) uses bits 5:4 as tens and bits 3:0 as units. A write is accepted only when tens*10+units is at most 23; otherwise the register is unchanged.
- R4: Register select 3 (day of month) uses bits 5:4 as tens and bits 3:0 as units. A write is accepted only when tens*10+units lies between 1 and 31; otherwise the register is unchanged.
- R5: An accepted write stores the whole written byte, including bit 7 and any bits outside the decoded digits. `rd_data` shows the register chosen by `rd_sel` in the same cycle.
- R6: Bit 7 of each register is its mask flag. With the flags written as {day,hour,min,sec}, the repeat rate is chosen as follows:
  - 0000 selects monthly.
  - 1000 selects daily.
  - 1100 selects hourly.
  - 1110 selects every minute.
  - Any other pattern selects every second.
- R7: The fields compared are:
  - monthly: day, hour, minute and second;
  - daily: hour, minute and second;
  - hourly: minute and second;
  - every minute: second only.
  Seconds and minutes compare bits 6:0, and hours and day compare bits 5:0.
- R8: `irq` is high for exactly the one cycle after a cycle in which `tick` is high and the compared fields match. It is never high without a tick in the cycle before.
- R9: At the every-second rate, every tick produces an `irq` pulse, whatever the current time is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | ADDR_W | Register select for writes (0 sec, 1 min, 2 hour, 3 day) |
| wr_data | input | DW | Write data (BCD with mask flag in bit 7) |
| rd_sel | input | ADDR_W | Register select for reads |
| rd_data | output | DW | Contents of the selected register |
| tick | input | 1 | One-cycle strobe each time the seconds count advances |
| cur_sec | input | DW | Current seconds, BCD |
| cur_min | input | DW | Current minutes, BCD |
| cur_hour | input | DW | Current hours, BCD |
| cur_mday | input | DW | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
The assertions check on every cycle that:
- a rejected write leaves every register stable;
- an accepted write lands in the selected register;
- the decoded rate is always exactly one of five;
- `irq` only follows a tick that matched;
- the every-second rate fires on each tick.

Other behaviour can only be shown by the bench's scenarios, because it depends on concrete values:
- which BCD encodings sit on each side of each range limit;
- that a masked field really drops out of the comparison while an unmasked one still blocks the alarm;
- the full mapping from flag patterns to rates.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NFIELD = 4;
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DAY  = 3;

  typedef enum logic [2:0] {
    RATE_MONTH = 3'd0,
    RATE_DAY   = 3'd1,
    RATE_HOUR  = 3'd2,
    RATE_MIN   = 3'd3,
    RATE_SEC   = 3'd4
  } rate_e;
  localparam int NRATE = 5;

  // Bits of a field that carry its BCD value.
  function automatic logic [7:0] keep_bits(input int idx);
    return (idx == FLD_SEC || idx == FLD_MIN) ? 8'h7F : 8'h3F;
  endfunction

  // Tens*10 + units of the kept bits.
  function automatic logic [6:0] bcd_dec(input logic [7:0] v, input logic [7:0] keep);
    logic [7:0] t;
    logic [6:0] hi;
    logic [6:0] lo;
    t  = v & keep;
    hi = {3'b000, t[7:4]};
    lo = {3'b000, t[3:0]};
    return hi * 7'd10 + lo;
  endfunction

  // Range check of a write for the given field.
  function automatic logic field_ok(input int idx, input logic [7:0] v);
    logic [6:0] d;
    d = bcd_dec(v, keep_bits(idx));
    case (idx)
      FLD_SEC, FLD_MIN: return d <= 7'd59;
      FLD_HOUR:         return d <= 7'd23;
      default:          return (d >= 7'd1) && (d <= 7'd31);
    endcase
  endfunction

  // Mask pattern {day,hour,min,sec} to repeat rate.
  function automatic rate_e rate_of(input logic [3:0] m);
    case (m)
      4'b0000: return RATE_MONTH;
      4'b1000: return RATE_DAY;
      4'b1100: return RATE_HOUR;
      4'b1110: return RATE_MIN;
      default: return RATE_SEC;
    endcase
  endfunction

  // Fields taking part in the comparison, bit i = field i.
  function automatic logic [3:0] fields_used(input rate_e r);
    case (r)
      RATE_MONTH: return 4'b1111;
      RATE_DAY:   return 4'b0111;
      RATE_HOUR:  return 4'b0011;
      RATE_MIN:   return 4'b0001;
      default:    return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
  import alm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ADDR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_sel,
  input  logic [DW-1:0]              wr_data,
  output logic [NFIELD-1:0][DW-1:0]  alm_q,
  output logic                       wr_ok
);
  logic [NFIELD-1:0] ok_vec;
  logic [NFIELD-1:0] hit_vec;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    assign hit_vec[i] = (wr_sel == ADDR_W'(i));
    assign ok_vec[i]  = field_ok(i, wr_data[7:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alm_q[i] <= '0;
      end else if (wr_en && hit_vec[i] && ok_vec[i]) begin
        alm_q[i] <= wr_data;
      end
    end
  end

  assign wr_ok = |(hit_vec & ok_vec);
endmodule

// File: rtl/alm_rate_decode.sv
module alm_rate_decode
  import alm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NFIELD-1:0][DW-1:0] alm_q,
  output rate_e                     rate,
  output logic [NRATE-1:0]          rate_oh
);
  logic [NFIELD-1:0] mask_bits;

  for (genvar i = 0; i < NFIELD; i++) begin : g_mask
    assign mask_bits[i] = alm_q[i][DW-1];
  end

  assign rate = rate_of(mask_bits);

  always_comb begin
    rate_oh = '0;
    rate_oh[rate] = 1'b1;
  end
endmodule

// File: rtl/alm_matcher.sv
module alm_matcher
  import alm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NFIELD-1:0][DW-1:0] alm_q,
  input  logic [NFIELD-1:0][DW-1:0] now_t,
  input  rate_e                     rate,
  output logic [NFIELD-1:0]         field_eq,
  output logic                      match_hit
);
  logic [NFIELD-1:0] used;

  assign used = fields_used(rate);

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    localparam logic [7:0] KEEP = keep_bits(i);
    assign field_eq[i] = ((alm_q[i][7:0] & KEEP) == (now_t[i][7:0] & KEEP));
  end

  assign match_hit = &(field_eq | ~used);
endmodule

// File: rtl/alm_irq_gen.sv
module alm_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match_hit,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick & match_hit;
  end
endmodule

// File: rtl/alm_match_ctrl.sv
module alm_match_ctrl
  import alm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_sel,
  output logic [DW-1:0]     rd_data,
  input  logic              tick,
  input  logic [DW-1:0]     cur_sec,
  input  logic [DW-1:0]     cur_min,
  input  logic [DW-1:0]     cur_hour,
  input  logic [DW-1:0]     cur_mday,
  output logic              irq
);
  logic [NFIELD-1:0][DW-1:0] alm_q;
  logic [NFIELD-1:0][DW-1:0] now_t;
  logic                      wr_ok;
  rate_e                     rate;
  logic [NRATE-1:0]          rate_oh;
  logic [NFIELD-1:0]         field_eq;
  logic                      match_hit;

  assign now_t = {cur_mday, cur_hour, cur_min, cur_sec};

  alm_regfile #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .alm_q(alm_q), .wr_ok(wr_ok)
  );

  alm_rate_decode #(.DW(DW)) u_rate (
    .alm_q(alm_q), .rate(rate), .rate_oh(rate_oh)
  );

  alm_matcher #(.DW(DW)) u_match (
    .alm_q(alm_q), .now_t(now_t), .rate(rate),
    .field_eq(field_eq), .match_hit(match_hit)
  );

  alm_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match_hit(match_hit), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (rd_sel == ADDR_W'(i)) rd_data = alm_q[i];
    end
  end
endmodule

// File: rtl/alm_match_ctrl_chk.sv
module alm_match_ctrl_chk
  import alm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ADDR_W = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_sel,
  input logic [DW-1:0]             wr_data,
  input logic                      wr_ok,
  input logic [NFIELD-1:0][DW-1:0] alm_q,
  input logic [NRATE-1:0]          rate_oh,
  input logic                      tick,
  input logic                      match_hit,
  input logic                      irq
);
  // R2 R3 R4: a rejected write changes nothing
  a_r2_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> $stable(alm_q));

  // R5: an accepted write lands whole in its register
  for (genvar i = 0; i < NFIELD; i++) begin : g_st
    a_r5_accept_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ok && wr_sel == ADDR_W'(i)) |=> (alm_q[i] == $past(wr_data)));
  end

  // R6: exactly one repeat rate at any time
  a_r6_rate_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rate_oh) == 1);

  // R8: a pulse only follows a matching tick
  a_r8_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(tick) && $past(match_hit)));

  // R8: no tick, no pulse next cycle
  a_r8_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq);

  // R9: every-second rate fires on each tick
  a_r9_sec_rate_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate_oh[RATE_SEC]) |=> irq);
endmodule

bind alm_match_ctrl alm_match_ctrl_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .wr_ok(wr_ok), .alm_q(alm_q), .rate_oh(rate_oh), .tick(tick),
  .match_hit(match_hit), .irq(irq)
);

// File: tb/alm_match_ctrl_tb.sv
`timescale 1ns/100ps
module alm_match_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_mday = '0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] mdl [4];
  bit   exp_q [$];
  string tag_q [$];
  logic pend = 1'b0;

  always #2.5 clk = ~clk;

  alm_match_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_mday(cur_mday), .irq(irq)
  );

  function automatic int dig(input logic [7:0] v, input int tens_mask);
    return ((int'(v) >> 4) & tens_mask) * 10 + (int'(v) & 15);
  endfunction

  function automatic bit legal(input int sel, input logic [7:0] v);
    int n;
    if (sel < 2) begin n = dig(v, 7); return n < 60; end
    n = dig(v, 3);
    if (sel == 2) return n < 24;
    return n > 0 && n < 32;
  endfunction

  function automatic bit model_fire(input logic [7:0] s, input logic [7:0] m,
                                    input logic [7:0] h, input logic [7:0] d);
    bit es, em, eh, ed;
    es = (mdl[0][6:0] == s[6:0]);
    em = (mdl[1][6:0] == m[6:0]);
    eh = (mdl[2][5:0] == h[5:0]);
    ed = (mdl[3][5:0] == d[5:0]);
    case ({mdl[3][7], mdl[2][7], mdl[1][7], mdl[0][7]})
      4'b0000: return es & em & eh & ed;
      4'b1000: return es & em & eh;
      4'b1100: return es & em;
      4'b1110: return es;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] v, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = v;
    if (legal(sel, v)) mdl[sel] = v;
    @(negedge clk);
    wr_en = 1'b0; rd_sel = 2'(sel);
    #1 check(rd_data == mdl[sel], req, rd_data, mdl[sel]);
  endtask

  task automatic do_tick(input logic [7:0] s, input logic [7:0] m,
                         input logic [7:0] h, input logic [7:0] d, input string req);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_mday = d; tick = 1'b1;
    exp_q.push_back(model_fire(s, m, h, d));
    tag_q.push_back(req);
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(posedge clk) pend <= tick;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pend) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(irq == e, t, irq, e);
      end else begin
        check(irq == 1'b0, "R8 no pulse without tick", irq, 0);
      end
    end
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1 check(rd_data == 8'h00, "R1 reset register", rd_data, 0);
    end
    check(irq == 1'b0, "R1 reset irq", irq, 0);
    rst_n = 1'b1;

    // R2 seconds/minutes range
    wr(0, 8'h59, "R2 sec 59 accepted");
    wr(0, 8'h60, "R2 sec 60 rejected");
    wr(0, 8'h5A, "R2 sec 5A rejected");
    wr(1, 8'h00, "R2 min 00 accepted");
    wr(1, 8'h7F, "R2 min 7F rejected");
    // R3 hours
    wr(2, 8'h24, "R3 hour 24 rejected");
    wr(2, 8'h23, "R3 hour 23 accepted");
    wr(2, 8'hE3, "R5 hour with bit6 and mask stored whole");
    // R4 day
    wr(3, 8'h00, "R4 day 00 rejected");
    wr(3, 8'h32, "R4 day 32 rejected");
    wr(3, 8'h31, "R4 day 31 accepted");
    wr(3, 8'h01, "R4 day 01 accepted");

    // R7 monthly: all fields compared
    wr(0, 8'h10, "R5 sec load"); wr(1, 8'h20, "R5 min load");
    wr(2, 8'h05, "R5 hour load"); wr(3, 8'h15, "R5 day load");
    do_tick(8'h10, 8'h20, 8'h05, 8'h15, "R7 monthly match");
    do_tick(8'h10, 8'h20, 8'h05, 8'h16, "R7 monthly day differs");
    do_tick(8'h11, 8'h20, 8'h05, 8'h15, "R7 monthly sec differs");
    // R8: matching time held without tick
    @(negedge clk);
    cur_sec = 8'h10; cur_min = 8'h20; cur_hour = 8'h05; cur_mday = 8'h15;
    repeat (5) @(negedge clk);

    // R6 daily
    wr(3, 8'h95, "R6 day mask set");
    do_tick(8'h10, 8'h20, 8'h05, 8'h02, "R6 daily other day fires");
    do_tick(8'h10, 8'h20, 8'h06, 8'h15, "R6 daily hour differs");
    // R6 hourly
    wr(2, 8'h85, "R6 hour mask set");
    do_tick(8'h10, 8'h20, 8'h17, 8'h09, "R6 hourly fires");
    do_tick(8'h10, 8'h21, 8'h05, 8'h15, "R6 hourly min differs");
    // R6 minute
    wr(1, 8'hA0, "R6 min mask set");
    do_tick(8'h10, 8'h44, 8'h11, 8'h28, "R6 minute fires");
    do_tick(8'h12, 8'h20, 8'h05, 8'h15, "R6 minute sec differs");
    // R7: upper bit of time sec ignored? bit 7 of time excluded from compare
    do_tick(8'h90, 8'h00, 8'h00, 8'h01, "R7 sec compares bits 6:0");
    // R9 every second
    wr(0, 8'h90, "R9 all masks set");
    do_tick(8'h33, 8'h01, 8'h02, 8'h03, "R9 all masks fires");
    do_tick(8'h00, 8'h00, 8'h00, 8'h01, "R9 all masks fires again");
    // R9 odd pattern: only seconds masked
    wr(3, 8'h15, "R6 clear day mask"); wr(2, 8'h05, "R6 clear hour mask");
    wr(1, 8'h20, "R6 clear min mask");
    do_tick(8'h47, 8'h59, 8'h23, 8'h30, "R9 odd pattern fires");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule